// File: doc/BRIEF.md
# Peripheral Software Reset Controller

This block lets software hold up to four serial-interface peripherals in reset and tells it when each one can be used again. Software writes through a small word-addressed register interface. One-cycle write strobes carry 32-bit data. A read strobe returns data on the following cycle.

Two registers can hold a peripheral in reset. The per-peripheral reset register has one bit for every peripheral. The compatibility reset register has bits only for the peripherals it covers, which by default are peripherals 0 to 2. Each peripheral's reset output is the OR of its bits in the two registers. The two registers keep their own contents: a write to one never changes what the other reads back. Neither register clears itself, so software writes a 1 to start a reset and a 0 to end it.

Release and readiness are separate events. A peripheral's ready bit drops in the same cycle its reset output rises. After the reset output falls, the ready bit stays low for a fixed number of clock cycles before it rises. If the reset comes back during that wait, the wait starts again from the beginning.

Top module: `periph_rst_ctrl`

## Requirements
- R1: The per-peripheral reset register is at word address 0. Bits [NUM_PERIPH-1:0] are read/write, with bit i belonging to peripheral i. All higher bits read as zero, and writing ones to them has no effect.
- R2: After system reset both reset registers read zero, every `periph_rst` bit is low, and every `periph_ready` bit is high.
- R3: `periph_rst[i]` is high exactly when bit i of the per-peripheral register or bit i of the compatibility register is 1. A write takes effect on the output in the cycle after its strobe, and a bit that was set stays set until software clears it.
- R4: The compatibility register is at word address 1. Bit i is read/write only for peripherals in LEGACY_MASK (default 0b0111, so bits 0 to 2). Every other bit reads zero, and writing it does not drive a reset.
- R5: A write to the per-peripheral register leaves the compatibility register's readback unchanged. A write to the compatibility register leaves the per-peripheral register's readback unchanged.
- R6: `periph_ready[i]` is low in every cycle in which `periph_rst[i]` is high.
- R7: After `periph_rst[i]` falls, `periph_ready[i]` rises on the READY_DELAY-th rising clock edge that follows. READY_DELAY defaults to 4.
- R8: If `periph_rst[i]` is asserted again before `periph_ready[i]` has risen, the full READY_DELAY wait restarts from the next release.
- R9: The ready status register is at word address 2. It returns `periph_ready` in bits [NUM_PERIPH-1:0] and zero above them. It is read-only, and writes to it change no state.
- R10: `rdata` takes, at the clock edge where `rd_en` is sampled high, the contents of the addressed register. It holds that value while `rd_en` is low. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | ADDR_W (4) | Word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid the cycle after `rd_en` |
| periph_rst | output | NUM_PERIPH (4) | Active-high reset, one bit per peripheral |
| periph_ready | output | NUM_PERIPH (4) | Ready status, one bit per peripheral |

## Verification
Resets are driven through each register on its own, through both registers on overlapping bits, and through the compatibility register on the bit it does not cover. These patterns separate a true OR of the two sources from a design that uses only one source or lets one register overwrite the other. Cross readback after each write shows whether the two registers stay independent. The ready timing is sampled on every cycle of a plain release and of a release interrupted mid-wait, so an off-by-one delay or a counter that does not restart shows up as a mismatch.

// File: rtl/prc_pkg.sv
package prc_pkg;
   localparam int unsigned ADDR_SPEC  = 0;
   localparam int unsigned ADDR_LEG   = 1;
   localparam int unsigned ADDR_READY = 2;

   function automatic int unsigned cnt_width(input int unsigned delay);
      return (delay < 2) ? 1 : $clog2(delay + 1);
   endfunction
endpackage

// File: rtl/prc_regfile.sv
module prc_regfile #(
   parameter int unsigned               NUM_PERIPH  = 4,
   parameter logic [NUM_PERIPH-1:0]     LEGACY_MASK = 4'b0111,
   parameter int unsigned               ADDR_W      = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [NUM_PERIPH-1:0] wfield,
   output logic [NUM_PERIPH-1:0] spec_q,
   output logic [NUM_PERIPH-1:0] leg_q
);
   import prc_pkg::*;

   logic wr_spec;
   logic wr_leg;

   assign wr_spec = wr_en && (addr == ADDR_W'(ADDR_SPEC));
   assign wr_leg  = wr_en && (addr == ADDR_W'(ADDR_LEG));

   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)       spec_q[i] <= 1'b0;
         else if (wr_spec) spec_q[i] <= wfield[i];
      end

      if (LEGACY_MASK[i]) begin : g_leg
         always_ff @(posedge clk) begin
            if (!rst_n)      leg_q[i] <= 1'b0;
            else if (wr_leg) leg_q[i] <= wfield[i];
         end
      end else begin : g_noleg
         assign leg_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/prc_ready_timer.sv
module prc_ready_timer #(
   parameter int unsigned READY_DELAY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic ready
);
   import prc_pkg::*;

   localparam int unsigned     CW   = cnt_width(READY_DELAY);
   localparam logic [CW-1:0]   TERM = CW'(READY_DELAY);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= TERM;
      else if (hold)           cnt_q <= '0;
      else if (cnt_q != TERM)  cnt_q <= cnt_q + 1'b1;
   end

   assign ready = !hold && (cnt_q == TERM);
endmodule

// File: rtl/prc_readback.sv
module prc_readback #(
   parameter int unsigned NUM_PERIPH = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [NUM_PERIPH-1:0] spec_q,
   input  logic [NUM_PERIPH-1:0] leg_q,
   input  logic [NUM_PERIPH-1:0] ready,
   output logic [DATA_W-1:0]     rdata
);
   import prc_pkg::*;

   logic [NUM_PERIPH-1:0] sel;
   logic [DATA_W-1:0]     rdata_q;

   always_comb begin
      case (addr)
         ADDR_W'(ADDR_SPEC):  sel = spec_q;
         ADDR_W'(ADDR_LEG):   sel = leg_q;
         ADDR_W'(ADDR_READY): sel = ready;
         default:             sel = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= DATA_W'(sel);
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/periph_rst_ctrl.sv
module periph_rst_ctrl #(
   parameter int unsigned           NUM_PERIPH  = 4,
   parameter logic [NUM_PERIPH-1:0] LEGACY_MASK = 4'b0111,
   parameter int unsigned           READY_DELAY = 4,
   parameter int unsigned           DATA_W      = 32,
   parameter int unsigned           ADDR_W      = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata,
   output logic [NUM_PERIPH-1:0] periph_rst,
   output logic [NUM_PERIPH-1:0] periph_ready
);
   if (NUM_PERIPH < 1 || NUM_PERIPH > DATA_W) begin : g_bad_num
      $error("periph_rst_ctrl: NUM_PERIPH must be 1..DATA_W");
   end
   if (READY_DELAY < 1) begin : g_bad_delay
      $error("periph_rst_ctrl: READY_DELAY must be at least 1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("periph_rst_ctrl: ADDR_W must be at least 2");
   end

   logic [NUM_PERIPH-1:0] spec_q;
   logic [NUM_PERIPH-1:0] leg_q;

   prc_regfile #(
      .NUM_PERIPH (NUM_PERIPH),
      .LEGACY_MASK(LEGACY_MASK),
      .ADDR_W     (ADDR_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wfield(wdata[NUM_PERIPH-1:0]),
      .spec_q(spec_q),
      .leg_q (leg_q)
   );

   assign periph_rst = spec_q | leg_q;

   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_tmr
      prc_ready_timer #(
         .READY_DELAY(READY_DELAY)
      ) u_tmr (
         .clk  (clk),
         .rst_n(rst_n),
         .hold (periph_rst[i]),
         .ready(periph_ready[i])
      );
   end

   prc_readback #(
      .NUM_PERIPH(NUM_PERIPH),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W)
   ) u_rb (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_en (rd_en),
      .addr  (addr),
      .spec_q(spec_q),
      .leg_q (leg_q),
      .ready (periph_ready),
      .rdata (rdata)
   );
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
   parameter int unsigned NUM_PERIPH = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic                  rd_en,
   input logic [ADDR_W-1:0]     addr,
   input logic [DATA_W-1:0]     wdata,
   input logic [DATA_W-1:0]     rdata,
   input logic [NUM_PERIPH-1:0] periph_rst,
   input logic [NUM_PERIPH-1:0] periph_ready
);
   import prc_pkg::*;

   AST_SPEC_SET_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(ADDR_SPEC)) |=>
      ((periph_rst & $past(wdata[NUM_PERIPH-1:0])) == $past(wdata[NUM_PERIPH-1:0]))); // R3

   AST_READY_LOW_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_ready & periph_rst) == '0); // R6

   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_rel
      AST_NOT_READY_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(periph_rst[i]) |-> !periph_ready[i]); // R7
   end

   AST_READY_REG_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(ADDR_READY)) |=> $stable(periph_rst)); // R9

   AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R10
endmodule

bind periph_rst_ctrl prc_checker #(
   .NUM_PERIPH(NUM_PERIPH),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W)
) u_prc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .rd_en       (rd_en),
   .addr        (addr),
   .wdata       (wdata),
   .rdata       (rdata),
   .periph_rst  (periph_rst),
   .periph_ready(periph_ready)
);

// File: tb/periph_rst_ctrl_bench.sv
`timescale 1ns/1ps
module periph_rst_ctrl_bench;
   localparam int N     = 4;
   localparam int DLY   = 4;
   localparam int DW    = 32;
   localparam int AW    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [N-1:0]  periph_rst;
   logic [N-1:0]  periph_ready;

   int n_vec = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   periph_rst_ctrl #(
      .NUM_PERIPH (N),
      .LEGACY_MASK(4'b0111),
      .READY_DELAY(DLY),
      .DATA_W     (DW),
      .ADDR_W     (AW)
   ) u_periph_rst_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .periph_rst(periph_rst), .periph_ready(periph_ready)
   );

   // scoreboard for reads
   logic [DW-1:0] exp_q[$];
   string         tag_q[$];
   logic          rd_seen = 1'b0;

   always @(posedge clk) rd_seen <= rd_en;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R10: unexpected read data %h, expected none", rdata);
         end else begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (rdata !== e) begin
               n_bad++;
               $display("FAIL %s: rdata got %h expected %h", t, rdata, e);
            end
         end
      end
   end

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, input logic [DW-1:0] e, input string t);
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(a);
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk(input string t, input logic [N-1:0] got, input logic [N-1:0] e);
      n_vec++;
      if (got !== e) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", t, got, e);
      end
   endtask

   task automatic countdown(input string t, input logic [N-1:0] bits);
      for (int k = 1; k <= DLY; k++) begin
         @(negedge clk);
         chk(t, periph_ready & bits, (k == DLY) ? bits : '0);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 rst after reset", periph_rst, 4'b0000);
      chk("R2 ready after reset", periph_ready, 4'b1111);
      rd(0, 32'h0, "R2 spec reg after reset");
      rd(1, 32'h0, "R2 legacy reg after reset");
      rd(2, 32'hF, "R9 ready reg after reset");

      wr(0, 32'h5);
      chk("R3 spec bits drive reset", periph_rst, 4'b0101);
      chk("R6 ready low in reset", periph_ready, 4'b1010);
      rd(1, 32'h0, "R5 legacy unchanged by spec write");
      rd(0, 32'h5, "R1 spec readback");

      wr(1, 32'hFFFF_FFFF);
      chk("R4 legacy OR, no bit3", periph_rst, 4'b0111);
      rd(1, 32'h7, "R4 legacy readback masked");
      rd(0, 32'h5, "R5 spec unchanged by legacy write");

      wr(0, 32'h0);
      chk("R3 legacy keeps reset after spec clear", periph_rst, 4'b0111);
      chk("R6 ready under legacy reset", periph_ready, 4'b1000);
      repeat (6) @(negedge clk);
      chk("R3 no self clear", periph_rst, 4'b0111);

      wr(1, 32'h0);
      chk("R3 released", periph_rst, 4'b0000);
      chk("R7 ready low at release", periph_ready & 4'b0111, 4'b0000);
      countdown("R7 ready delay", 4'b0111);

      wr(0, 32'hFFFF_FFF0);
      chk("R1 upper bits no reset", periph_rst, 4'b0000);
      rd(0, 32'h0, "R1 upper bits read zero");

      wr(0, 32'h8);
      chk("R3 peripheral 3 spec reset", periph_rst, 4'b1000);
      wr(0, 32'h0);
      @(negedge clk);
      chk("R8 still counting", periph_ready[3], 1'b0);
      wr(0, 32'h8);
      wr(0, 32'h0);
      chk("R8 ready low after restart", periph_ready, 4'b0111);
      countdown("R8 full restart delay", 4'b1000);

      wr(2, 32'h0);
      chk("R9 write to ready reg inert", periph_rst, 4'b0000);
      rd(2, 32'hF, "R9 ready reg readback");
      rd(7, 32'h0, "R10 unmapped reads zero");
      @(negedge clk);
      chk("R10 rdata held", rdata[N-1:0], 4'b0000);

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R10: got %0d pending reads expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule